// File: doc/BRIEF.md
# SATA PHY Reset and Receive-PLL Lock Sequencer

This block brings a SATA PHY out of reset and confirms that its receive PLL has locked. The PHY's own register space is only reachable indirectly, through a control-register access master that accepts three kinds of request: address, write and read. The sequencer drives that master one request at a time and waits for each reply before it moves on. Each reply is a done strobe, which may carry an error flag, and read replies also carry a data word.

After an accepted start, the block selects the PHY clock/reset register and writes its reset bit. It then enters a poll loop. Each pass of the loop waits a programmable number of cycles, selects the lane status register and reads it. The pass ends the sequence with success when the lock bit is set. If a bounded number of reads go by without lock, the block reports a timeout. An error from any request ends the sequence at once with an access-error code.

A start is only honoured once the PHY reference clock enable has been high for a programmable settle time and no sequence is running.

Top module: `phy_rst_lock_seq`

## Requirements
- R1: A start pulse is accepted only when the block is idle and `refclk_on` has been high without a break for at least `SETTLE_CYC` cycles. Otherwise it is ignored: `busy` stays low and no request is issued.
- R2: In the cycle after an accepted start, `busy` is high and an address request (kind 0) carrying `RST_REG` (0x7F3F) is issued. Once that request is answered, a write request (kind 1) follows, carrying a word with only bit `RST_BIT` (bit 0) set, i.e. 0x0001.
- R3: Each request is a `req_valid` pulse one cycle long. No new request is issued until `rsp_done` has answered the previous one.
- R4: After the write is answered, and after every read that does not see lock, the block waits `POLL_DLY_CYC` cycles. The next address request therefore appears `POLL_DLY_CYC`+1 cycles after the `rsp_done` cycle. Its data is `STAT_REG` (0x2003), and a read request (kind 2, data 0) follows it.
- R5: A read answer with bit `LOCK_BIT` (bit 1) set ends the sequence with `ok`=1 and `err_code`=0.
- R6: If `MAX_TRIES` (10) reads all lack the lock bit, the sequence ends with `ok`=0 and `err_code`=1 (timeout), and no further request is issued.
- R7: A `rsp_done` that carries `rsp_err` ends the sequence at once, on any step. The result is `ok`=0 and `err_code`=2 (access error), and no further request is issued.
- R8: `done` is a one-cycle pulse in the cycle after the final `rsp_done`, and `busy` is low in that cycle.
- R9: `ok` and `err_code` hold their values while idle. An accepted start clears both to 0 in the following cycle.
- R10: A start that arrives while a sequence runs is ignored. Each accepted start yields exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refclk_on | input | 1 | PHY reference PLL clock enabled |
| start | input | 1 | Request to run the sequence |
| req_valid | output | 1 | One-cycle request strobe to the access master |
| req_kind | output | 2 | Request kind: 0 address, 1 write, 2 read |
| req_data | output | DATA_W | Register address or write data |
| rsp_done | input | 1 | Access master has finished the current request |
| rsp_err | input | 1 | The finished request failed (valid with rsp_done) |
| rsp_rdata | input | DATA_W | Read data (valid with rsp_done of a read) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ok | output | 1 | Last sequence saw PLL lock |
| err_code | output | 2 | 0 none, 1 timeout, 2 access error |

## Verification
The bench checks timing in cycles against its own free-running cycle counter, which it samples on falling edges. The first request and the `busy` rise are due one cycle after start is sampled. Each later request is due one cycle after the answer to the request before it, except the status-address request, which is due `POLL_DLY_CYC`+1 cycles after the preceding answer. `done` is due exactly one cycle after the final answer. The responder model records the cycle of every answer, and the scoreboard compares each gap with these fixed distances. A start placed one cycle before the settle window closes exercises the admission boundary.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [1:0] {
      REQ_ADDR  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_READ  = 2'd2
   } req_kind_e;

   typedef enum logic [1:0] {
      RES_NONE    = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_ACCESS  = 2'd2
   } seq_res_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RA_ISSUE,
      S_RA_WAIT,
      S_WR_ISSUE,
      S_WR_WAIT,
      S_DLY,
      S_PA_ISSUE,
      S_PA_WAIT,
      S_RD_ISSUE,
      S_RD_WAIT
   } seq_state_e;

endpackage

// File: rtl/seq_settle.sv
// Reports ready once the clock enable has been held high for SETTLE_CYC cycles.
module seq_settle #(
   parameter int unsigned SETTLE_CYC = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_on,
   output logic ready
);

   generate
      if (SETTLE_CYC == 0) begin : g_direct
         assign ready = clk_on;
      end else begin : g_count
         localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!clk_on)
               cnt_q <= '0;
            else if (cnt_q != LIM)
               cnt_q <= cnt_q + CW'(1);
         end

         assign ready = (cnt_q == LIM);
      end
   endgenerate

endmodule

// File: rtl/seq_delay.sv
// Down counter: after a load, expired rises in the DLY_CYC-th following cycle.
module seq_delay #(
   parameter int unsigned DLY_CYC = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int unsigned CW = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(DLY_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= RELOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_try_ctr.sv
// Counts poll attempts; last flags the final permitted attempt.
module seq_try_ctr #(
   parameter int unsigned MAX_TRIES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int unsigned TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
   localparam logic [TW-1:0] LAST_V = TW'(MAX_TRIES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc && cnt_q != LAST_V)
         cnt_q <= cnt_q + TW'(1);
   end

   assign last = (cnt_q == LAST_V);

endmodule

// File: rtl/phy_rst_lock_seq.sv
module phy_rst_lock_seq
   import phy_seq_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned RST_REG      = 'h7F3F,
   parameter int unsigned STAT_REG     = 'h2003,
   parameter int unsigned RST_BIT      = 0,
   parameter int unsigned LOCK_BIT     = 1,
   parameter int unsigned MAX_TRIES    = 10,
   parameter int unsigned POLL_DLY_CYC = 15000,
   parameter int unsigned SETTLE_CYC   = 15000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              refclk_on,
   input  logic              start,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic [DATA_W-1:0] req_data,
   input  logic              rsp_done,
   input  logic              rsp_err,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic              busy,
   output logic              done,
   output logic              ok,
   output logic [1:0]        err_code
);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
         $error("DATA_W must lie in 8..32");
      end
      if (LOCK_BIT >= DATA_W || RST_BIT >= DATA_W) begin : g_bad_bit
         $error("LOCK_BIT and RST_BIT must lie inside DATA_W");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (POLL_DLY_CYC < 1) begin : g_bad_dly
         $error("POLL_DLY_CYC must be at least 1");
      end
   endgenerate

   localparam logic [DATA_W-1:0] RST_ADDR_V  = RST_REG[DATA_W-1:0];
   localparam logic [DATA_W-1:0] STAT_ADDR_V = STAT_REG[DATA_W-1:0];
   localparam logic [DATA_W-1:0] RST_WR_V    = DATA_W'(1) << RST_BIT;

   seq_state_e state_q, state_d;
   logic       ready, dly_load, dly_expired, try_clr, try_inc, try_last;
   logic       fin, fin_ok, accept;
   seq_res_e   fin_code;
   logic       done_q, ok_q;
   logic [1:0] code_q;

   seq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .clk_on (refclk_on),
      .ready  (ready)
   );

   seq_delay #(.DLY_CYC(POLL_DLY_CYC)) u_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (dly_load),
      .expired (dly_expired)
   );

   seq_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (try_clr),
      .inc   (try_inc),
      .last  (try_last)
   );

   assign accept = (state_q == S_IDLE) && start && ready;

   always_comb begin
      state_d  = state_q;
      dly_load = 1'b0;
      try_clr  = 1'b0;
      try_inc  = 1'b0;
      fin      = 1'b0;
      fin_ok   = 1'b0;
      fin_code = RES_NONE;
      unique case (state_q)
         S_IDLE:     if (accept) state_d = S_RA_ISSUE;
         S_RA_ISSUE: state_d = S_RA_WAIT;
         S_RA_WAIT: begin
            if (rsp_done) begin
               if (rsp_err) begin
                  fin = 1'b1; fin_code = RES_ACCESS;
               end else begin
                  state_d = S_WR_ISSUE;
               end
            end
         end
         S_WR_ISSUE: state_d = S_WR_WAIT;
         S_WR_WAIT: begin
            if (rsp_done) begin
               if (rsp_err) begin
                  fin = 1'b1; fin_code = RES_ACCESS;
               end else begin
                  state_d  = S_DLY;
                  dly_load = 1'b1;
                  try_clr  = 1'b1;
               end
            end
         end
         S_DLY:      if (dly_expired) state_d = S_PA_ISSUE;
         S_PA_ISSUE: state_d = S_PA_WAIT;
         S_PA_WAIT: begin
            if (rsp_done) begin
               if (rsp_err) begin
                  fin = 1'b1; fin_code = RES_ACCESS;
               end else begin
                  state_d = S_RD_ISSUE;
               end
            end
         end
         S_RD_ISSUE: state_d = S_RD_WAIT;
         S_RD_WAIT: begin
            if (rsp_done) begin
               if (rsp_err) begin
                  fin = 1'b1; fin_code = RES_ACCESS;
               end else if (rsp_rdata[LOCK_BIT]) begin
                  fin = 1'b1; fin_ok = 1'b1;
               end else if (try_last) begin
                  fin = 1'b1; fin_code = RES_TIMEOUT;
               end else begin
                  state_d  = S_DLY;
                  dly_load = 1'b1;
                  try_inc  = 1'b1;
               end
            end
         end
         default: state_d = S_IDLE;
      endcase
      if (fin) state_d = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
         code_q  <= RES_NONE;
      end else begin
         state_q <= state_d;
         done_q  <= fin;
         if (accept) begin
            ok_q   <= 1'b0;
            code_q <= RES_NONE;
         end else if (fin) begin
            ok_q   <= fin_ok;
            code_q <= fin_code;
         end
      end
   end

   always_comb begin
      req_valid = 1'b0;
      req_kind  = REQ_ADDR;
      req_data  = '0;
      case (state_q)
         S_RA_ISSUE: begin req_valid = 1'b1; req_kind = REQ_ADDR;  req_data = RST_ADDR_V;  end
         S_WR_ISSUE: begin req_valid = 1'b1; req_kind = REQ_WRITE; req_data = RST_WR_V;    end
         S_PA_ISSUE: begin req_valid = 1'b1; req_kind = REQ_ADDR;  req_data = STAT_ADDR_V; end
         S_RD_ISSUE: begin req_valid = 1'b1; req_kind = REQ_READ;  req_data = '0;          end
         default: ;
      endcase
   end

   assign busy     = (state_q != S_IDLE);
   assign done     = done_q;
   assign ok       = ok_q;
   assign err_code = code_q;

endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       ok,
   input logic [1:0] err_code,
   input logic       req_valid,
   input logic [1:0] req_kind,
   input logic       rsp_done,
   input logic       rsp_err
);

   assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_first_req_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (req_valid && req_kind == 2'd0));

   assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy);

   assert_ok_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> (err_code == 2'd0));

   assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_done && rsp_err) |=> (done && !ok && err_code == 2'd2));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(rsp_done)));

   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !busy) |-> ($stable(ok) && $stable(err_code)));

endmodule

bind phy_rst_lock_seq phy_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .ok        (ok),
   .err_code  (err_code),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .rsp_done  (rsp_done),
   .rsp_err   (rsp_err)
);

// File: tb/tb_phy_rst_lock_seq.sv
module tb_phy_rst_lock_seq;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 8;
   localparam int DLY        = 5;
   localparam int TRIES      = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        refclk_on = 1'b0;
   logic        start = 1'b0;
   logic        req_valid;
   logic [1:0]  req_kind;
   logic [15:0] req_data;
   logic        rsp_done;
   logic        rsp_err;
   logic [15:0] rsp_rdata;
   logic        busy, done, ok;
   logic [1:0]  err_code;

   phy_rst_lock_seq #(
      .DATA_W(16), .MAX_TRIES(TRIES), .POLL_DLY_CYC(DLY), .SETTLE_CYC(SETTLE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .refclk_on(refclk_on), .start(start),
      .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .busy(busy), .done(done), .ok(ok), .err_code(err_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0, n_done = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // responder model of the access master
   int lock_read = -1, err_req = -1, lat = 1;
   int req_idx = 0, reads_seen = 0, last_rsp_cyc = 0;

   initial begin
      rsp_done = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
      @(negedge clk);
      forever begin
         if (req_valid) begin
            automatic int k = req_idx;
            automatic int rd_i = reads_seen;
            automatic int kind = int'(req_kind);
            if (k == 0) begin
               chk("R2 first kind", kind, 0);
               chk("R2 first data", int'(req_data), 'h7F3F);
            end else if (k == 1) begin
               chk("R2 write kind", kind, 1);
               chk("R2 write data", int'(req_data), 'h0001);
            end else if (k % 2 == 0) begin
               chk("R4 poll addr kind", kind, 0);
               chk("R4 poll addr data", int'(req_data), 'h2003);
               chk("R4 poll gap", cyc - last_rsp_cyc, DLY + 1);
            end else begin
               chk("R4 read kind", kind, 2);
               chk("R4 read data", int'(req_data), 0);
            end
            if (kind == 2) reads_seen++;
            req_idx++;
            for (int w = 0; w < lat; w++) begin
               @(negedge clk);
               if (req_valid) chk("R3 request while waiting", 1, 0);
            end
            rsp_done  = 1'b1;
            rsp_err   = (k == err_req);
            rsp_rdata = (kind == 2 && rd_i == lock_read) ? 16'h0002 : 16'hFFFD;
            last_rsp_cyc = cyc;
            @(negedge clk);
            rsp_done = 1'b0; rsp_err = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // scoreboard
   typedef struct packed { logic ok; logic [1:0] code; logic [7:0] reads; } exp_t;
   exp_t exp_q[$];

   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            n_done++;
            if (exp_q.size() == 0) begin
               chk("R10 unexpected done", 1, 0);
            end else begin
               automatic exp_t e = exp_q.pop_front();
               chk("R5/R6/R7 ok", int'(ok), int'(e.ok));
               chk("R5/R6/R7 code", int'(err_code), int'(e.code));
               chk("R6 reads issued", reads_seen, int'(e.reads));
               chk("R8 done timing", cyc - last_rsp_cyc, 1);
               chk("R8 busy at done", int'(busy), 0);
            end
            @(negedge clk);
            chk("R8 done width", int'(done), 0);
            chk("R7 no request after end", int'(req_valid), 0);
         end
      end
   end

   task automatic run(input int lk, input int er, input int e_ok, input int e_code,
                      input int e_reads, input int lt, input bit poke);
      automatic int d0 = n_done;
      automatic exp_t e;
      lock_read = lk; err_req = er; lat = lt; req_idx = 0; reads_seen = 0;
      e.ok = e_ok[0]; e.code = e_code[1:0]; e.reads = e_reads[7:0];
      exp_q.push_back(e);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R2 busy after start", int'(busy), 1);
      chk("R9 ok cleared", int'(ok), 0);
      chk("R9 code cleared", int'(err_code), 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (n_done == d0) @(negedge clk);
      repeat (2) @(negedge clk);
      if (poke) begin
         repeat (4) @(negedge clk);
         chk("R10 single done", n_done - d0, 1);
         chk("R10 idle after", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset done", int'(done), 0);
      chk("R1 reset busy", int'(busy), 0);
      chk("R3 reset req", int'(req_valid), 0);
      chk("R9 reset ok", int'(ok), 0);
      chk("R9 reset code", int'(err_code), 0);

      // R1: start with clock off is ignored
      start = 1'b1; @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk("R1 start without clock", int'(busy), 0);
      // R1: one cycle short of settle
      refclk_on = 1'b1;
      repeat (SETTLE - 1) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R1 start before settle", int'(busy), 0);
      chk("R1 no request before settle", int'(req_valid), 0);
      repeat (2) @(negedge clk);

      run(0, -1, 1, 0, 1, 1, 1'b0);          // R5 lock on first read
      run(3, -1, 1, 0, 4, 2, 1'b0);          // R5 lock on fourth read
      run(TRIES - 1, -1, 1, 0, TRIES, 1, 1'b0); // R5 lock on last allowed read
      run(-1, -1, 0, 1, TRIES, 1, 1'b0);     // R6 timeout
      repeat (5) @(negedge clk);
      chk("R9 code held", int'(err_code), 1);
      chk("R9 ok held", int'(ok), 0);
      run(-1, 0, 0, 2, 0, 1, 1'b0);          // R7 error on reset address
      run(-1, 1, 0, 2, 0, 2, 1'b0);          // R7 error on reset write
      run(-1, 4, 0, 2, 1, 1, 1'b0);          // R7 error on second status address
      run(-1, 7, 0, 2, 3, 1, 1'b0);          // R7 error on third read
      run(1, -1, 1, 0, 2, 3, 1'b1);          // R10 start while busy

      // R1: a dropped clock enable restarts the settle window
      refclk_on = 1'b0; @(negedge clk); refclk_on = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R1 start after clock drop", int'(busy), 0);
      repeat (SETTLE + 2) @(negedge clk);
      run(2, -1, 1, 0, 3, 1, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule